// File: doc/BRIEF.md
# Quasi-resonant switching cycle timer

This block sets the timing of every switching cycle in a valley-switching flyback controller. It runs from one clock and takes four inputs. The first is an 8-bit feedback code sampled by an external converter. The second is a one-cycle valley pulse from a ringing detector. The third is a current-limit flag from a comparator. The fourth is an enable from the supervisor. It drives a single gate-on request. Every time constant is a parameter in clock counts. The defaults assume a 50 MHz clock: 8 µs / 38 µs minimum off time, 9 µs valley timeout, 45 µs on-time cap, 300 ns blanking, and 550 µs / 30 µs restart.

The minimum off time depends on load. At heavy load it is short. Below a light-load feedback level it grows linearly, and it holds its longest value once feedback falls below a deep-light-load level. That level has hysteresis. Valley pulses count only after the minimum off time has elapsed. The first valley after that point starts the next on period. If no valley arrives, a fixed timeout starts it instead. After enable, or after reset, a restart timer launches the first pulse. Its period depends on feedback: short when feedback is above the open-loop level, long otherwise.

Top module: `qr_cycle_timer`

## Requirements
- R1: While `en` is low, `gate` is low. A falling `en` forces `gate` low on the next clock and clears all timers. Re-enabling therefore waits a full restart period again.
- R2: After reset or after `en` rises, the first pulse starts after a restart wait. The wait is START_FAST_CYC cycles when `fb_code` > FB_OLP, and START_SLOW_CYC cycles otherwise. Counting starts at the sample where `en` is first seen high.
- R3: An on period never lasts more than TON_MAX_CYC cycles. Without a current limit, it lasts exactly that long.
- R4: During the first BLANK_CYC cycles of each on period, `ilim` is ignored. A short pulse in that window does not shorten the period. A flag held from the first cycle ends the period after BLANK_CYC+1 cycles.
- R5: If `ilim` is high in on cycle k (counting from 0) and k ≥ BLANK_CYC, the on period ends after k+1 cycles.
- R6: The minimum off time is TOFF_LO_CYC when `fb_code` ≥ FB_GREEN_ON. It is TOFF_HI_CYC when `fb_code` ≤ FB_GREEN_OFF.
- R7: For FB_GREEN_OFF < `fb_code` < FB_GREEN_ON, the minimum off time is TOFF_LO_CYC + floor((TOFF_HI_CYC−TOFF_LO_CYC)·(FB_GREEN_ON−fb)/(FB_GREEN_ON−FB_GREEN_OFF)).
- R8: Once `fb_code` < FB_GREEN_OFF, the minimum off time stays at TOFF_HI_CYC. This holds until `fb_code` ≥ FB_GREEN_OFF+FB_GREEN_HYST.
- R9: A valley pulse that arrives while the minimum off time is still running has no effect.
- R10: A valley pulse in off cycle j (counting from 0), where j ≥ the minimum off time, starts the gate at the next clock. The off period then lasts j+1 cycles.
- R11: With no valley, the off period lasts the minimum off time plus TIMEOUT_CYC cycles. The next on period then starts.
- R12: The value of the minimum off time is fixed at the falling edge of the gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable from the supervisor |
| fb_code | input | 8 | Sampled feedback code, unsigned |
| valley | input | 1 | One-cycle valley pulse |
| ilim | input | 1 | Current-limit comparator flag |
| gate | output | 1 | Gate-on request |

## Verification
Every internal state of this block shows up at the port as the length of a gate-high or gate-low run. A wrong sequencer state, counter or latched off time therefore shows up in the very next run. It appears as an off period that is too short or too long, a pulse that ends early or late, or a restart wait of the wrong length. A wrong hysteresis flag changes the off time of every cycle until feedback crosses the release level. The bench counts each run in clock samples and compares it with values worked out from the requirements.

// File: rtl/qrt_pkg.sv
package qrt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ON     = 2'd1,
        ST_OFFMIN = 2'd2,
        ST_ARMED  = 2'd3
    } qrt_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/qrt_toff_calc.sv
module qrt_toff_calc #(
    parameter int FB_W          = 8,
    parameter int CW            = 16,
    parameter int TOFF_LO_CYC   = 400,
    parameter int TOFF_HI_CYC   = 1900,
    parameter int FB_GREEN_ON   = 107,
    parameter int FB_GREEN_OFF  = 61,
    parameter int FB_GREEN_HYST = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FB_W-1:0] fb_code,
    output logic [CW-1:0]   toff_cnt
);
    localparam int SPAN  = TOFF_HI_CYC - TOFF_LO_CYC;
    localparam int RANGE = FB_GREEN_ON - FB_GREEN_OFF;
    localparam int REL   = FB_GREEN_OFF + FB_GREEN_HYST;

    logic deep_d, deep_q;
    logic [31:0] fb32, depth, prod, quo;

    always_comb begin
        fb32   = 32'(fb_code);
        deep_d = deep_q;
        if (fb32 < 32'(FB_GREEN_OFF))
            deep_d = 1'b1;
        else if (fb32 >= 32'(REL))
            deep_d = 1'b0;

        depth = 32'(FB_GREEN_ON) - fb32;
        prod  = depth * 32'(SPAN);
        quo   = prod / 32'(RANGE);

        if (deep_q)
            toff_cnt = CW'(TOFF_HI_CYC);
        else if (fb32 >= 32'(FB_GREEN_ON))
            toff_cnt = CW'(TOFF_LO_CYC);
        else if (fb32 <= 32'(FB_GREEN_OFF))
            toff_cnt = CW'(TOFF_HI_CYC);
        else
            toff_cnt = CW'(32'(TOFF_LO_CYC) + quo);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) deep_q <= 1'b0;
        else        deep_q <= deep_d;
    end

    // R6/R7 bound: off time never leaves the endpoint range
    p_toff_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (toff_cnt >= CW'(TOFF_LO_CYC)) && (toff_cnt <= CW'(TOFF_HI_CYC)));

endmodule

// File: rtl/qrt_start_sel.sv
module qrt_start_sel #(
    parameter int FB_W           = 8,
    parameter int CW             = 16,
    parameter int START_SLOW_CYC = 27500,
    parameter int START_FAST_CYC = 1500,
    parameter int FB_OLP         = 214
) (
    input  logic [FB_W-1:0] fb_code,
    output logic [CW-1:0]   start_cnt
);
    always_comb begin
        if (32'(fb_code) > 32'(FB_OLP))
            start_cnt = CW'(START_FAST_CYC);
        else
            start_cnt = CW'(START_SLOW_CYC);
    end
endmodule

// File: rtl/qrt_seq.sv
module qrt_seq
    import qrt_pkg::*;
#(
    parameter int CW          = 16,
    parameter int TON_MAX_CYC = 2250,
    parameter int BLANK_CYC   = 15,
    parameter int TIMEOUT_CYC = 450
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          valley,
    input  logic          ilim,
    input  logic [CW-1:0] toff_in,
    input  logic [CW-1:0] start_in,
    output logic          gate_o
);
    typedef struct packed {
        qrt_state_e    st;
        logic [CW-1:0] cnt;
        logic [CW-1:0] toff;
    } seq_t;

    seq_t d, q;

    always_comb begin
        d     = q;
        d.cnt = q.cnt + CW'(1);
        case (q.st)
            ST_IDLE: begin
                if (q.cnt >= start_in - CW'(1)) begin
                    d.st  = ST_ON;
                    d.cnt = '0;
                end
            end
            ST_ON: begin
                if ((q.cnt >= CW'(TON_MAX_CYC - 1)) ||
                    (ilim && (q.cnt >= CW'(BLANK_CYC)))) begin
                    d.st   = ST_OFFMIN;
                    d.cnt  = '0;
                    d.toff = toff_in;
                end
            end
            ST_OFFMIN: begin
                if (q.cnt >= q.toff - CW'(1)) begin
                    d.st  = ST_ARMED;
                    d.cnt = '0;
                end
            end
            default: begin
                if (valley || (q.cnt >= CW'(TIMEOUT_CYC - 1))) begin
                    d.st  = ST_ON;
                    d.cnt = '0;
                end
            end
        endcase
        if (!en) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.cnt  <= '0;
            q.toff <= CW'(1);
        end else begin
            q <= d;
        end
    end

    assign gate_o = (q.st == ST_ON);

    // Run-length observers for the assertions
    logic [CW-1:0] high_run_q, low_run_q;
    logic          after_on_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_run_q <= '0;
            low_run_q  <= '0;
            after_on_q <= 1'b0;
        end else begin
            high_run_q <= gate_o ? high_run_q + CW'(1) : '0;
            if (gate_o)
                low_run_q <= '0;
            else if (low_run_q != '1)
                low_run_q <= low_run_q + CW'(1);
            if (!en)         after_on_q <= 1'b0;
            else if (gate_o) after_on_q <= 1'b1;
        end
    end

    p_gate_off_when_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !gate_o);

    p_on_time_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |-> (high_run_q < CW'(TON_MAX_CYC)));

    p_blank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o && en && (high_run_q < CW'(BLANK_CYC))) |=> gate_o);

    p_min_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_o) && after_on_q) |-> (low_run_q >= q.toff));

    p_valley_starts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_ARMED) && valley && en) |=> gate_o);

endmodule

// File: rtl/qr_cycle_timer.sv
module qr_cycle_timer
    import qrt_pkg::*;
#(
    parameter int FB_W           = 8,
    parameter int TOFF_LO_CYC    = 400,
    parameter int TOFF_HI_CYC    = 1900,
    parameter int TIMEOUT_CYC    = 450,
    parameter int TON_MAX_CYC    = 2250,
    parameter int BLANK_CYC      = 15,
    parameter int START_SLOW_CYC = 27500,
    parameter int START_FAST_CYC = 1500,
    parameter int FB_GREEN_ON    = 107,
    parameter int FB_GREEN_OFF   = 61,
    parameter int FB_GREEN_HYST  = 5,
    parameter int FB_OLP         = 214
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [FB_W-1:0] fb_code,
    input  logic            valley,
    input  logic            ilim,
    output logic            gate
);
    localparam int MAXC = max2(max2(max2(TOFF_HI_CYC, TIMEOUT_CYC), TON_MAX_CYC),
                               max2(START_SLOW_CYC, START_FAST_CYC));
    localparam int CW   = $clog2(MAXC + 2) + 1;

    logic [CW-1:0] toff_cnt, start_cnt;

    qrt_toff_calc #(
        .FB_W(FB_W), .CW(CW),
        .TOFF_LO_CYC(TOFF_LO_CYC), .TOFF_HI_CYC(TOFF_HI_CYC),
        .FB_GREEN_ON(FB_GREEN_ON), .FB_GREEN_OFF(FB_GREEN_OFF),
        .FB_GREEN_HYST(FB_GREEN_HYST)
    ) u_toff (
        .clk(clk), .rst_n(rst_n), .fb_code(fb_code), .toff_cnt(toff_cnt)
    );

    qrt_start_sel #(
        .FB_W(FB_W), .CW(CW),
        .START_SLOW_CYC(START_SLOW_CYC), .START_FAST_CYC(START_FAST_CYC),
        .FB_OLP(FB_OLP)
    ) u_start (
        .fb_code(fb_code), .start_cnt(start_cnt)
    );

    qrt_seq #(
        .CW(CW), .TON_MAX_CYC(TON_MAX_CYC),
        .BLANK_CYC(BLANK_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .valley(valley), .ilim(ilim),
        .toff_in(toff_cnt), .start_in(start_cnt), .gate_o(gate)
    );

endmodule

// File: tb/qr_cycle_timer_bench.sv
module qr_cycle_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 2000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] fb_code = 8'd0;
    logic       valley = 1'b0;
    logic       ilim = 1'b0;
    logic       gate;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench parameters: TOFF 20..80, TIMEOUT 10, TON 50, BLANK 4,
    // restart 200/30, feedback levels 100/60, hyst 5, open-loop 200
    qr_cycle_timer #(
        .FB_W(8), .TOFF_LO_CYC(20), .TOFF_HI_CYC(80), .TIMEOUT_CYC(10),
        .TON_MAX_CYC(50), .BLANK_CYC(4), .START_SLOW_CYC(200),
        .START_FAST_CYC(30), .FB_GREEN_ON(100), .FB_GREEN_OFF(60),
        .FB_GREEN_HYST(5), .FB_OLP(200)
    ) u_qr_cycle_timer (
        .clk(clk), .rst_n(rst_n), .en(en), .fb_code(fb_code),
        .valley(valley), .ilim(ilim), .gate(gate)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            finish_run();
        end
    end

    task automatic check_eq(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic measure_low(output int n);
        n = 0;
        while (gate == 1'b0 && n < LIMIT) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic measure_high(output int n);
        n = 0;
        while (gate == 1'b1 && n < LIMIT) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Disable, set feedback, re-enable, check restart wait and first pulse
    task automatic start_run(input int fb, input int exp_start, input string req);
        int n;
        en = 1'b0;
        repeat (3) @(negedge clk);
        fb_code = 8'(fb);
        repeat (3) @(negedge clk);
        en = 1'b1;
        measure_low(n);
        check_eq(req, n, exp_start);
        measure_high(n);
        check_eq("R3 full on period", n, 50);
    endtask

    task automatic t_reset();
        int n;
        repeat (4) @(negedge clk);
        check_eq("R1 gate low in reset", int'(gate), 0);
        rst_n = 1'b1;
        n = 0;
        repeat (10) begin
            @(negedge clk);
            if (gate) n++;
        end
        check_eq("R1 gate low while disabled", n, 0);
    endtask

    task automatic t_restart_slow();
        int n;
        start_run(50, 200, "R2 slow restart");
        measure_low(n);
        check_eq("R6 R11 deep light-load off + timeout", n, 90);
        check_eq("R3 after timeout gate rises", int'(gate), 1);
    endtask

    task automatic t_restart_fast();
        int n;
        start_run(220, 30, "R2 fast restart");
        measure_low(n);
        check_eq("R6 R11 heavy-load off + timeout", n, 30);
    endtask

    task automatic t_interp();
        int n;
        start_run(80, 200, "R2 slow restart mid feedback");
        measure_low(n);
        check_eq("R7 fb 80 off time", n, 50 + 10);
        start_run(100, 200, "R2 slow restart at entry level");
        measure_low(n);
        check_eq("R6 fb at entry level", n, 30);
        start_run(61, 200, "R2 slow restart fb 61");
        measure_low(n);
        check_eq("R7 fb 61 off time", n, 78 + 10);
        start_run(60, 200, "R2 slow restart fb 60");
        measure_low(n);
        check_eq("R6 fb at deep level", n, 90);
    endtask

    task automatic t_hyst();
        int n;
        en = 1'b0;
        fb_code = 8'd50;
        repeat (4) @(negedge clk);
        start_run(62, 200, "R2 slow restart hyst");
        measure_low(n);
        check_eq("R8 held at longest inside band", n, 90);
        start_run(65, 200, "R2 slow restart release");
        measure_low(n);
        check_eq("R8 released at band top", n, 72 + 10);
    endtask

    task automatic t_valley();
        int n;
        start_run(220, 30, "R2 fast restart valley");
        n = 0;
        while (gate == 1'b0 && n < LIMIT) begin
            valley = (n == 5) || (n == 23);
            @(negedge clk);
            n++;
        end
        valley = 1'b0;
        // pulse at 5 is inside the 20-cycle minimum off window
        check_eq("R9 R10 first armed valley starts gate", n, 24);
        measure_high(n);
        check_eq("R3 on after valley", n, 50);
        n = 0;
        while (gate == 1'b0 && n < LIMIT) begin
            valley = (n == 19);
            @(negedge clk);
            n++;
        end
        valley = 1'b0;
        check_eq("R9 valley in last blocked cycle ignored", n, 30);
        measure_high(n);
        n = 0;
        while (gate == 1'b0 && n < LIMIT) begin
            valley = (n == 20);
            @(negedge clk);
            n++;
        end
        valley = 1'b0;
        check_eq("R10 valley at first armed cycle", n, 21);
    endtask

    task automatic t_blank();
        int n;
        start_run(220, 30, "R2 fast restart blank");
        measure_low(n);
        n = 0;
        while (gate == 1'b1 && n < LIMIT) begin
            ilim = (n == 2);
            @(negedge clk);
            n++;
        end
        ilim = 1'b0;
        check_eq("R4 pulse inside blanking ignored", n, 50);
        measure_low(n);
        ilim = 1'b1;
        measure_high(n);
        ilim = 1'b0;
        check_eq("R4 held flag ends after blank", n, 5);
        measure_low(n);
        check_eq("R11 off after limited pulse", n, 30);
        n = 0;
        while (gate == 1'b1 && n < LIMIT) begin
            ilim = (n == 12);
            @(negedge clk);
            n++;
        end
        ilim = 1'b0;
        check_eq("R5 limit at cycle 12", n, 13);
    endtask

    task automatic t_latch();
        int n;
        start_run(220, 30, "R2 fast restart latch");
        measure_low(n);
        // change feedback during the on period only after the fall
        measure_high(n);
        fb_code = 8'd50;
        measure_low(n);
        check_eq("R12 off time fixed at falling edge", n, 30);
        measure_high(n);
        measure_low(n);
        check_eq("R12 new feedback used next cycle", n, 90);
    endtask

    task automatic t_disable();
        int n;
        int hi;
        start_run(220, 30, "R2 fast restart disable");
        measure_low(n);
        n = 0;
        while (gate == 1'b1 && n < 7) begin
            @(negedge clk);
            n++;
        end
        en = 1'b0;
        @(negedge clk);
        check_eq("R1 gate low next clock after disable", int'(gate), 0);
        hi = 0;
        repeat (40) begin
            @(negedge clk);
            if (gate) hi++;
        end
        check_eq("R1 gate stays low while disabled", hi, 0);
        en = 1'b1;
        measure_low(n);
        check_eq("R1 full restart wait after re-enable", n, 30);
    endtask

    initial begin
        t_reset();
        t_restart_slow();
        t_restart_fast();
        t_interp();
        t_hyst();
        t_valley();
        t_blank();
        t_latch();
        t_disable();
        finish_run();
    end

endmodule